// File: doc/BRIEF.md
# Serial EEPROM Slave Address Front-End

This block sits between the two-wire bus pins and the memory controller of a serial EEPROM slave. It samples the clock and data lines with the system clock and finds the bus conditions that open and close a transfer. It then takes in the first byte after an opening condition and checks that byte's device-type field. When the byte is addressed to this part, the block acknowledges it on the data line and hands the transfer direction and the upper array-address bits to the controller.

The byte's three middle bits are never compared against strap pins. A density parameter decides how many of them, counted from the bottom, carry upper memory-array address bits. The others are don't-care bits. The word-address byte, data transfer, the write cycle and the array itself belong to the controller behind this block.

The result leaves as a one-cycle valid pulse with no ready input. The consumer cannot apply back-pressure and must take the payload in the cycle that valid is high. The payload stays unchanged until the next accepted address byte.

Top module: `twi_eeprom_addr_front`

## Requirements
- R1: While reset is held and directly after it, `sda_oe_o` and `hit_valid_o` are 0.
- R2: Bus activity before the first opening condition is ignored. A full byte and ninth clock with no opening condition produce no acknowledge and no valid pulse.
- R3: When the top four bits of the first byte after an opening condition are 1010, `sda_oe_o` goes high (pulling data low) after the falling clock edge that ends the eighth bit. It stays high through the whole ninth clock and is released after the falling edge that ends that clock.
- R4: On a device-type mismatch, `sda_oe_o` is never driven and no valid pulse is produced. The block then ignores the bus until the next opening condition.
- R5: Each accepted byte raises `hit_valid_o` for exactly one system-clock cycle. `hit_rw_o` equals the last bit of the byte, where 1 means read and 0 means write.
- R6: `hit_upper_o[k]` carries byte bit k+1 for k below `DENSITY_BITS` and is 0 otherwise. The middle bits never affect whether the byte matches.
- R7: An opening condition part-way through an address byte restarts reception, so the following eight bits form the address.
- R8: A closing condition (data rising while clock is high) in any state returns the block to idle. Later bits without a fresh opening condition are ignored.
- R9: When a data change and a clock rise land in the same system-clock sample, the change counts as the new data bit and not as a bus condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low (open-drain acknowledge) |
| hit_valid_o | output | 1 | One-cycle pulse: address accepted |
| hit_rw_o | output | 1 | Direction of the accepted byte, 1 = read |
| hit_upper_o | output | 3 | Upper array-address bits, unused positions 0 |

## Verification
The clock-rise detector and the condition detector both look at the same pair of synchronized samples. A data edge that arrives in the same sample as a clock rise could therefore be read either as a bit or as an opening or closing condition. The bench provokes this by driving the data and clock lines in the same timestep for every bit of one address byte. It judges the outcome by whether the acknowledge appears and whether the decoded upper bits and direction equal those of the byte as sent. A second instance with a smaller density runs on the same wires, so each transfer also checks the masking.

// File: rtl/twi_af_pkg.sv
package twi_af_pkg;
  localparam int BYTE_BITS = 8;
  localparam int MID_BITS  = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_PASS
  } af_state_e;

  typedef struct packed {
    logic                rw;
    logic [MID_BITS-1:0] upper;
  } af_hit_t;
endpackage

// File: rtl/twi_af_sync.sv
module twi_af_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/twi_af_cond.sv
module twi_af_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  // A condition needs the clock high in both samples; a data change that
  // coincides with a clock rise is therefore a data bit.
  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/twi_af_engine.sv
module twi_af_engine
  import twi_af_pkg::*;
#(
  parameter int         DENSITY_BITS = 2,
  parameter logic [3:0] DEV_TYPE     = 4'b1010
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_rise_i,
  input  logic                scl_fall_i,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                sda_s_i,
  output logic                sda_oe_o,
  output logic                hit_valid_o,
  output af_hit_t             hit_o
);
  localparam int          CNT_W    = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);

  af_state_e            state;
  logic [BYTE_BITS-1:0] shreg;
  logic [CNT_W-1:0]     nbits;
  logic [MID_BITS-1:0]  upper_m;
  logic                 match;

  for (genvar k = 0; k < MID_BITS; k++) begin : g_mask
    if (k < DENSITY_BITS) begin : g_addr
      assign upper_m[k] = shreg[k+1];
    end else begin : g_dc
      assign upper_m[k] = 1'b0;
    end
  end

  assign match = (shreg[BYTE_BITS-1 -: 4] == DEV_TYPE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      shreg       <= '0;
      nbits       <= '0;
      sda_oe_o    <= 1'b0;
      hit_valid_o <= 1'b0;
      hit_o       <= '0;
    end else begin
      hit_valid_o <= 1'b0;
      if (stop_i) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_i) begin
        state    <= ST_ADDR;
        nbits    <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise_i && nbits != LAST_BIT) begin
              shreg <= {shreg[BYTE_BITS-2:0], sda_s_i};
              nbits <= nbits + 1'b1;
            end else if (scl_fall_i && nbits == LAST_BIT) begin
              if (match) begin
                state       <= ST_ACK;
                sda_oe_o    <= 1'b1;
                hit_valid_o <= 1'b1;
                hit_o.rw    <= shreg[0];
                hit_o.upper <= upper_m;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              state    <= ST_PASS;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_eeprom_addr_front.sv
module twi_eeprom_addr_front
  import twi_af_pkg::*;
#(
  parameter int         DENSITY_BITS = 2,
  parameter logic [3:0] DEV_TYPE     = 4'b1010,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       hit_valid_o,
  output logic       hit_rw_o,
  output logic [2:0] hit_upper_o
);
  logic    scl_s, sda_s;
  logic    scl_rise_w, scl_fall_w, start_w, stop_w;
  af_hit_t hit_w;

  twi_af_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s)
  );
  twi_af_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s)
  );

  twi_af_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_o(scl_rise_w), .scl_fall_o(scl_fall_w),
    .start_o(start_w), .stop_o(stop_w)
  );

  twi_af_engine #(.DENSITY_BITS(DENSITY_BITS), .DEV_TYPE(DEV_TYPE)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .scl_rise_i(scl_rise_w), .scl_fall_i(scl_fall_w),
    .start_i(start_w), .stop_i(stop_w), .sda_s_i(sda_s),
    .sda_oe_o(sda_oe_o), .hit_valid_o(hit_valid_o), .hit_o(hit_w)
  );

  assign hit_rw_o    = hit_w.rw;
  assign hit_upper_o = hit_w.upper;
endmodule

// File: rtl/twi_af_checker.sv
module twi_af_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_fall,
  input logic start_evt,
  input logic stop_evt,
  input logic sda_oe,
  input logic hit_valid
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!sda_oe && !hit_valid));

  assert_ack_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  assert_release_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> $past(scl_fall || stop_evt || start_evt));

  assert_hit_with_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> sda_oe);

  assert_hit_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |=> !hit_valid);

  assert_stop_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);
endmodule

bind twi_eeprom_addr_front twi_af_checker chk_i (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall_w), .start_evt(start_w),
  .stop_evt(stop_w), .sda_oe(sda_oe_o), .hit_valid(hit_valid_o)
);

// File: tb/twi_eeprom_addr_front_tb_top.sv
module twi_eeprom_addr_front_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_bus;
  logic       oe_a, oe_b, hv_a, hv_b, rw_a, rw_b;
  logic [2:0] up_a, up_b;
  int         checks = 0, failures = 0;
  int         hits_a = 0, hits_b = 0, run_a = 0, max_run_a = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~oe_a & ~oe_b;

  twi_eeprom_addr_front #(.DENSITY_BITS(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(oe_a), .hit_valid_o(hv_a), .hit_rw_o(rw_a), .hit_upper_o(up_a)
  );
  twi_eeprom_addr_front #(.DENSITY_BITS(1)) dut_lo_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(oe_b), .hit_valid_o(hv_b), .hit_rw_o(rw_b), .hit_upper_o(up_b)
  );

  always @(negedge clk) begin
    if (hv_a) begin hits_a++; run_a++; end else run_a = 0;
    if (run_a > max_run_a) max_run_a = run_a;
    if (hv_b) hits_b++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic scl_low();
    wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_bit(input bit b, input bit same_step);
    if (same_step) begin
      wq(); sda_m = b; scl_m = 1'b1;
    end else begin
      sda_m = b; wq(); scl_m = 1'b1;
    end
    wq(2); scl_m = 1'b0; wq();
  endtask

  // Sends a byte then a ninth clock; reports acknowledge and release.
  task automatic send_byte(input logic [7:0] v, input bit same_step,
                           output bit acked, output bit released);
    for (int i = 7; i >= 0; i--) send_bit(v[i], same_step);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    acked = ~sda_bus; wq(); scl_m = 1'b0; wq();
    released = sda_bus;
  endtask

  task automatic t_reset();
    check(!oe_a && !hv_a, "R1 reset outputs", {oe_a, hv_a}, 0);
    rst_n = 1'b1; wq();
    check(!oe_a && !hv_a && !oe_b, "R1 after reset", {oe_a, hv_a, oe_b}, 0);
  endtask

  task automatic t_no_start();
    bit ak, rl; int h0 = hits_a;
    scl_low();
    send_byte(8'hA1, 0, ak, rl);
    check(!ak, "R2 no ack before start", ak, 0);
    check(hits_a == h0, "R2 no hit before start", hits_a - h0, 0);
  endtask

  task automatic t_match(input logic [7:0] v, input bit same_step, input string req);
    bit ak, rl; int h0 = hits_a, hb = hits_b;
    start_c();
    send_byte(v, same_step, ak, rl);
    check(ak, {req, " ack driven"}, ak, 1);
    check(rl, "R3 released after ninth clock", rl, 1);
    check(hits_a == h0 + 1, {req, " one hit"}, hits_a - h0, 1);
    check(rw_a == v[0], "R5 direction bit", rw_a, v[0]);
    check(up_a == v[3:1], "R6 upper bits density 3", up_a, v[3:1]);
    check(hits_b == hb + 1 && up_b == {2'b00, v[1]} && rw_b == v[0],
          "R6 upper bits density 1", up_b, {2'b00, v[1]});
    stop_c();
  endtask

  task automatic t_mismatch();
    bit ak, rl; int h0 = hits_a;
    start_c();
    send_byte(8'hB6, 0, ak, rl);
    check(!ak, "R4 no ack on mismatch", ak, 0);
    check(hits_a == h0, "R4 no hit on mismatch", hits_a - h0, 0);
    send_byte(8'hA0, 0, ak, rl);
    check(!ak && hits_a == h0, "R4 idle until next start", ak, 0);
    stop_c();
  endtask

  task automatic t_restart();
    bit ak, rl; int h0 = hits_a;
    start_c();
    send_bit(1, 0); send_bit(0, 0); send_bit(1, 0);
    start_c();
    send_byte(8'hA2, 0, ak, rl);
    check(ak, "R7 ack after repeated start", ak, 1);
    check(hits_a == h0 + 1 && up_a == 3'b001 && rw_a == 1'b0,
          "R7 payload from restarted byte", up_a, 1);
    stop_c();
  endtask

  task automatic t_stop_mid();
    bit ak, rl; int h0 = hits_a;
    start_c();
    send_bit(1, 0); send_bit(0, 0); send_bit(1, 0); send_bit(0, 0);
    stop_c();
    scl_low();
    send_byte(8'hA0, 0, ak, rl);
    check(!ak, "R8 no ack after stop", ak, 0);
    check(hits_a == h0, "R8 no hit after stop", hits_a - h0, 0);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
  endtask

  initial begin
    wq(2);
    t_reset();
    t_no_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    t_match(8'hA6, 0, "R3");
    check(max_run_a == 1, "R5 single-cycle pulse", max_run_a, 1);
    t_match(8'hAD, 0, "R5");
    t_mismatch();
    t_restart();
    t_stop_mid();
    t_match(8'hA4, 1, "R9");
    t_match(8'hAB, 1, "R9");
    check(max_run_a == 1, "R5 pulse width overall", max_run_a, 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule